// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing byte of a two-operand instruction into an operand location. It takes the 2-bit mode field, the 3-bit register/memory field, the byte/word bit, a displacement, the four pointer/index registers (the base pair and the two index registers) and the four segment base registers. For a memory operand it forms the 16-bit effective offset, picks the default segment, and produces a 20-bit physical address. For a register operand it reports the register code and width.

A request is one `req_valid` cycle while the block is idle. All request inputs are captured on that edge. A small sequencer then forms the base/index sum, adds the displacement and performs the segment translation, one step per clock. The result is presented for exactly one cycle on `out_valid`. Requests that arrive while the sequencer is busy are dropped.

The sequencer has six states:
- IDLE waits for a request.
- SUM forms base plus index.
- DISP adds the displacement.
- XLAT adds the shifted segment.
- MEMOUT presents a memory result.
- REGOUT presents a register result.

Transitions:
- IDLE goes to REGOUT when the mode is 11 and to SUM for any other mode.
- SUM goes to DISP, DISP goes to XLAT, and XLAT goes to MEMOUT.
- MEMOUT and REGOUT both return to IDLE.

Top module: `eagen_top`

## Requirements
- R1: After reset the block is idle, and `out_valid`, `out_is_reg`, `out_offset`, `out_phys` and `out_seg` are all zero until a request is accepted.
- R2: For modes 00, 01 and 10, the r/m codes select the offset base as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX.
- R3: Mode 00 adds no displacement, except in the case covered by R6.
- R4: Mode 01 adds the low 8 bits of `req_disp`, sign-extended to 16 bits. The upper 8 bits of `req_disp` have no effect.
- R5: Mode 10 adds all 16 bits of `req_disp`.
- R6: Mode 00 with r/m 6 is a direct address. The offset equals `req_disp`, no register contributes, and the data segment is used.
- R7: Mode 11 yields a register result one cycle after the accepting edge:
  - `out_is_reg` is 1.
  - `out_reg_code` equals r/m (AL/AX=0, CL/CX=1, DL/DX=2, BL/BX=3, AH/SP=4, CH/BP=5, DH/SI=6, BH/DI=7).
  - `out_wide` equals the W bit.
- R8: The physical address is (segment << 4) + offset, taken modulo 2^20.
- R9: The effective offset wraps modulo 2^16.
- R10: Memory modes that use BP default to the stack segment, with `out_seg` = 10. All other memory modes use the data segment, with `out_seg` = 11. The segment codes are ES=00, CS=01, SS=10, DS=11.
- R11: A memory result is valid for exactly one cycle. It appears after the fourth rising edge, counting the accepting edge as the first.
- R12: A request while the block is not idle is ignored. Results depend only on the inputs captured at the accepting edge, even if register or segment inputs change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_mod | input | 2 | Mode field |
| req_rm | input | 3 | Register/memory field |
| req_wide | input | 1 | W bit: 0 byte, 1 word |
| req_disp | input | 16 | Displacement (low byte used in mode 01) |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | Extra segment base |
| seg_cs | input | 16 | Code segment base |
| seg_ss | input | 16 | Stack segment base |
| seg_ds | input | 16 | Data segment base |
| out_valid | output | 1 | Result valid for one cycle |
| out_is_reg | output | 1 | Result is a register operand |
| out_reg_code | output | 3 | Register code (register result) |
| out_wide | output | 1 | Captured W bit |
| out_seg | output | 2 | Segment code used (memory result) |
| out_offset | output | 16 | Effective offset (memory result) |
| out_phys | output | 20 | Physical address (memory result) |

## Verification
The hardest situation to reach from the ports is a request, or a change of register and segment inputs, that lands while a memory computation is still in its SUM, DISP or XLAT state. In that case the design must keep using the captured operands and must drop the new request. The stimulus reaches it by holding `req_valid` high across several consecutive cycles with different fields, and by rewriting every register and segment input on each of those cycles. A behavioural model that tracks the busy window cycle by cycle decides which request should be accepted. The stimulus also covers wrap-around at both the 16-bit offset and the 20-bit physical address, and an 8-bit displacement whose upper byte holds junk.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_DISP,
        ST_XLAT,
        ST_MEMOUT,
        ST_REGOUT
    } st_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_e;

    typedef enum logic [1:0] {
        DSP_NONE  = 2'b00,
        DSP_SHORT = 2'b01,
        DSP_LONG  = 2'b10
    } dsp_e;

    typedef struct packed {
        logic use_bx;
        logic use_bp;
        logic use_si;
        logic use_di;
        dsp_e dsp;
        seg_e seg;
    } plan_t;

    localparam logic [1:0] MODE_REG = 2'b11;
    localparam logic [1:0] MODE_NOD = 2'b00;
    localparam logic [2:0] RM_DIRECT = 3'd6;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import eagen_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    output plan_t      plan
);
    always_comb begin
        plan = '0;
        plan.seg = SEG_DS;
        unique case (mode)
            2'b00:   plan.dsp = DSP_NONE;
            2'b01:   plan.dsp = DSP_SHORT;
            2'b10:   plan.dsp = DSP_LONG;
            default: plan.dsp = DSP_NONE;
        endcase
        unique case (rm)
            3'd0: begin plan.use_bx = 1'b1; plan.use_si = 1'b1; end
            3'd1: begin plan.use_bx = 1'b1; plan.use_di = 1'b1; end
            3'd2: begin plan.use_bp = 1'b1; plan.use_si = 1'b1; end
            3'd3: begin plan.use_bp = 1'b1; plan.use_di = 1'b1; end
            3'd4: plan.use_si = 1'b1;
            3'd5: plan.use_di = 1'b1;
            3'd6: begin
                if (mode == MODE_NOD) plan.dsp = DSP_LONG;
                else                  plan.use_bp = 1'b1;
            end
            default: plan.use_bx = 1'b1;
        endcase
        if (plan.use_bp && mode != MODE_REG) plan.seg = SEG_SS;
    end
endmodule

// File: rtl/ea_offset.sv
module ea_offset
    import eagen_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int DSP8_W = 8
)(
    input  plan_t              plan,
    input  logic [OFF_W-1:0]   bx,
    input  logic [OFF_W-1:0]   bp,
    input  logic [OFF_W-1:0]   si,
    input  logic [OFF_W-1:0]   di,
    input  logic [OFF_W-1:0]   disp,
    output logic [OFF_W-1:0]   base_sum,
    output logic [OFF_W-1:0]   disp_ext
);
    localparam int EXT_W = OFF_W - DSP8_W;

    logic [OFF_W-1:0] t_bx, t_bp, t_si, t_di;

    always_comb begin
        t_bx = plan.use_bx ? bx : '0;
        t_bp = plan.use_bp ? bp : '0;
        t_si = plan.use_si ? si : '0;
        t_di = plan.use_di ? di : '0;
        base_sum = t_bx + t_bp + t_si + t_di;
    end

    always_comb begin
        unique case (plan.dsp)
            DSP_SHORT: disp_ext = {{EXT_W{disp[DSP8_W-1]}}, disp[DSP8_W-1:0]};
            DSP_LONG:  disp_ext = disp;
            default:   disp_ext = '0;
        endcase
    end
endmodule

// File: rtl/ea_xlat.sv
module ea_xlat #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int N_SEG     = 4,
    localparam int PHYS_W   = OFF_W + SEG_SHIFT,
    localparam int SEL_W    = $clog2(N_SEG)
)(
    input  logic [N_SEG-1:0][OFF_W-1:0] seg_bank,
    input  logic [SEL_W-1:0]            seg_sel,
    input  logic [OFF_W-1:0]            offset,
    output logic [PHYS_W-1:0]           phys
);
    logic [N_SEG-1:0][OFF_W-1:0] gated;
    logic [OFF_W-1:0]            seg_val;

    for (genvar g = 0; g < N_SEG; g++) begin : g_pick
        assign gated[g] = (seg_sel == SEL_W'(g)) ? seg_bank[g] : '0;
    end

    always_comb begin
        seg_val = '0;
        for (int i = 0; i < N_SEG; i++) seg_val = seg_val | gated[i];
        phys = {seg_val, {SEG_SHIFT{1'b0}}} + PHYS_W'(offset);
    end
endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int DSP8_W    = 8,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFF_W + SEG_SHIFT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mod,
    input  logic [2:0]        req_rm,
    input  logic              req_wide,
    input  logic [OFF_W-1:0]  req_disp,
    input  logic [OFF_W-1:0]  reg_bx,
    input  logic [OFF_W-1:0]  reg_bp,
    input  logic [OFF_W-1:0]  reg_si,
    input  logic [OFF_W-1:0]  reg_di,
    input  logic [OFF_W-1:0]  seg_es,
    input  logic [OFF_W-1:0]  seg_cs,
    input  logic [OFF_W-1:0]  seg_ss,
    input  logic [OFF_W-1:0]  seg_ds,
    output logic              out_valid,
    output logic              out_is_reg,
    output logic [2:0]        out_reg_code,
    output logic              out_wide,
    output logic [1:0]        out_seg,
    output logic [OFF_W-1:0]  out_offset,
    output logic [PHYS_W-1:0] out_phys
);
    localparam int N_SEG = 4;

    st_e st, st_nx;

    logic [1:0]                  mod_q;
    logic [2:0]                  rm_q;
    logic                        wide_q;
    logic [OFF_W-1:0]            disp_q, bx_q, bp_q, si_q, di_q;
    logic [N_SEG-1:0][OFF_W-1:0] cap_seg;
    logic [OFF_W-1:0]            base_q, off_q;
    logic [PHYS_W-1:0]           phys_q;

    plan_t             plan;
    logic [OFF_W-1:0]  base_w, disp_w;
    logic [PHYS_W-1:0] phys_w;
    logic              accept;

    assign accept = (st == ST_IDLE) && req_valid;

    ea_decode u_dec (
        .mode (mod_q),
        .rm   (rm_q),
        .plan (plan)
    );

    ea_offset #(.OFF_W(OFF_W), .DSP8_W(DSP8_W)) u_off (
        .plan     (plan),
        .bx       (bx_q),
        .bp       (bp_q),
        .si       (si_q),
        .di       (di_q),
        .disp     (disp_q),
        .base_sum (base_w),
        .disp_ext (disp_w)
    );

    ea_xlat #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .N_SEG(N_SEG)) u_xlat (
        .seg_bank (cap_seg),
        .seg_sel  (plan.seg),
        .offset   (off_q),
        .phys     (phys_w)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (req_valid) st_nx = (req_mod == MODE_REG) ? ST_REGOUT : ST_SUM;
            ST_SUM:    st_nx = ST_DISP;
            ST_DISP:   st_nx = ST_XLAT;
            ST_XLAT:   st_nx = ST_MEMOUT;
            ST_MEMOUT: st_nx = ST_IDLE;
            ST_REGOUT: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // operand capture and datapath stages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q   <= '0;
            rm_q    <= '0;
            wide_q  <= 1'b0;
            disp_q  <= '0;
            bx_q    <= '0;
            bp_q    <= '0;
            si_q    <= '0;
            di_q    <= '0;
            cap_seg <= '0;
            base_q  <= '0;
            off_q   <= '0;
            phys_q  <= '0;
        end else begin
            if (accept) begin
                mod_q   <= req_mod;
                rm_q    <= req_rm;
                wide_q  <= req_wide;
                disp_q  <= req_disp;
                bx_q    <= reg_bx;
                bp_q    <= reg_bp;
                si_q    <= reg_si;
                di_q    <= reg_di;
                cap_seg <= {seg_ds, seg_ss, seg_cs, seg_es};
            end
            if (st == ST_SUM)  base_q <= base_w;
            if (st == ST_DISP) off_q  <= base_q + disp_w;
            if (st == ST_XLAT) phys_q <= phys_w;
        end
    end

    // outputs
    always_comb begin
        out_valid    = 1'b0;
        out_is_reg   = 1'b0;
        out_reg_code = '0;
        out_wide     = 1'b0;
        out_seg      = '0;
        out_offset   = '0;
        out_phys     = '0;
        unique case (st)
            ST_REGOUT: begin
                out_valid    = 1'b1;
                out_is_reg   = 1'b1;
                out_reg_code = rm_q;
                out_wide     = wide_q;
            end
            ST_MEMOUT: begin
                out_valid  = 1'b1;
                out_wide   = wide_q;
                out_seg    = plan.seg;
                out_offset = off_q;
                out_phys   = phys_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eagen_chk.sv
module eagen_chk
    import eagen_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFF_W + SEG_SHIFT
)(
    input logic                  clk,
    input logic                  rst_n,
    input st_e                   st,
    input logic                  req_valid,
    input logic [1:0]            req_mod,
    input logic                  out_valid,
    input logic                  out_is_reg,
    input logic [1:0]            out_seg,
    input logic [OFF_W-1:0]      out_offset,
    input logic [PHYS_W-1:0]     out_phys,
    input logic [3:0][OFF_W-1:0] cap_seg
);
    logic [OFF_W-1:0] seg_pick;
    assign seg_pick = cap_seg[out_seg];

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_reg_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req_valid && req_mod == 2'b11) |=> (out_valid && out_is_reg));

    assert_busy_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && req_valid) |=> !(out_valid && out_is_reg));

    assert_seg_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_reg) |-> (out_seg == SEG_SS || out_seg == SEG_DS));

    assert_phys_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_reg) |->
            (out_phys == ({seg_pick, {SEG_SHIFT{1'b0}}} + PHYS_W'(out_offset))));
endmodule

bind eagen_top eagen_chk #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .req_valid  (req_valid),
    .req_mod    (req_mod),
    .out_valid  (out_valid),
    .out_is_reg (out_is_reg),
    .out_seg    (out_seg),
    .out_offset (out_offset),
    .out_phys   (out_phys),
    .cap_seg    (cap_seg)
);

// File: tb/tb_eagen_top.sv
module tb_eagen_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mod = '0;
    logic [2:0]  req_rm = '0;
    logic        req_wide = 1'b0;
    logic [15:0] req_disp = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic        out_valid, out_is_reg, out_wide;
    logic [2:0]  out_reg_code;
    logic [1:0]  out_seg;
    logic [15:0] out_offset;
    logic [19:0] out_phys;

    // staging values, copied onto the pins at the next drive point
    logic [15:0] t_bx = '0, t_bp = '0, t_si = '0, t_di = '0;
    logic [15:0] t_es = '0, t_cs = '0, t_ss = '0, t_ds = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int          m_stage = 0;
    bit          e_isreg;
    logic [2:0]  e_code;
    logic        e_wide;
    logic [1:0]  e_seg;
    logic [15:0] e_off;
    logic [19:0] e_phys;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    eagen_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mod(req_mod),
        .req_rm(req_rm), .req_wide(req_wide), .req_disp(req_disp),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .out_valid(out_valid), .out_is_reg(out_is_reg), .out_reg_code(out_reg_code),
        .out_wide(out_wide), .out_seg(out_seg), .out_offset(out_offset), .out_phys(out_phys)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_off(input logic [1:0] m, input logic [2:0] r,
                                            input logic [15:0] d, input logic [15:0] bx,
                                            input logic [15:0] bp, input logic [15:0] si,
                                            input logic [15:0] di);
        logic [31:0] s;
        logic [15:0] dd;
        case (r)
            3'd0: s = bx + si;
            3'd1: s = bx + di;
            3'd2: s = bp + si;
            3'd3: s = bp + di;
            3'd4: s = {16'h0, si};
            3'd5: s = {16'h0, di};
            3'd6: s = (m == 2'b00) ? 32'h0 : {16'h0, bp};
            default: s = {16'h0, bx};
        endcase
        if (m == 2'b00)      dd = (r == 3'd6) ? d : 16'h0;
        else if (m == 2'b01) dd = {{8{d[7]}}, d[7:0]};
        else                 dd = d;
        s = s + {16'h0, dd};
        return s[15:0];
    endfunction

    // compare DUT outputs with the model state after the last edge
    task automatic compare();
        bit ev;
        ev = (m_stage == 1);
        chk(ev ? e_tag : "R11", "out_valid", {31'h0, out_valid}, {31'h0, ev});
        if (ev) begin
            chk(e_tag, "out_is_reg", {31'h0, out_is_reg}, {31'h0, e_isreg});
            chk(e_tag, "out_wide", {31'h0, out_wide}, {31'h0, e_wide});
            if (e_isreg) begin
                chk(e_tag, "out_reg_code", {29'h0, out_reg_code}, {29'h0, e_code});
            end else begin
                chk(e_tag, "out_seg", {30'h0, out_seg}, {30'h0, e_seg});
                chk(e_tag, "out_offset", {16'h0, out_offset}, {16'h0, e_off});
                chk(e_tag, "out_phys", {12'h0, out_phys}, {12'h0, e_phys});
            end
        end
    endtask

    // advance the model across the coming rising edge
    task automatic model_edge(input string tag);
        logic [15:0] sv;
        if (m_stage != 0) begin
            m_stage--;
        end else if (req_valid && rst_n) begin
            e_tag  = tag;
            e_wide = req_wide;
            if (req_mod == 2'b11) begin
                m_stage = 1;
                e_isreg = 1;
                e_code  = req_rm;
            end else begin
                m_stage = 4;
                e_isreg = 0;
                e_off   = ref_off(req_mod, req_rm, req_disp, reg_bx, reg_bp, reg_si, reg_di);
                if (req_rm == 3'd2 || req_rm == 3'd3 || (req_rm == 3'd6 && req_mod != 2'b00)) begin
                    e_seg = 2'b10; sv = seg_ss;
                end else begin
                    e_seg = 2'b11; sv = seg_ds;
                end
                e_phys = 20'(({4'h0, sv} << 4) + {4'h0, e_off});
            end
        end
    endtask

    task automatic step(input logic rq, input logic [1:0] m, input logic [2:0] r,
                        input logic w, input logic [15:0] d, input string tag);
        @(negedge clk);
        compare();
        req_valid = rq; req_mod = m; req_rm = r; req_wide = w; req_disp = d;
        reg_bx = t_bx; reg_bp = t_bp; reg_si = t_si; reg_di = t_di;
        seg_es = t_es; seg_cs = t_cs; seg_ss = t_ss; seg_ds = t_ds;
        model_edge(tag);
    endtask

    task automatic txn(input logic [1:0] m, input logic [2:0] r, input logic w,
                       input logic [15:0] d, input string tag);
        step(1'b1, m, r, w, d, tag);
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 3'd0, 1'b0, 16'h0, tag);
    endtask

    task automatic load_regs();
        t_bx = 16'h1200; t_bp = 16'h3400; t_si = 16'h0056; t_di = 16'h0078;
        t_es = 16'h1111; t_cs = 16'h2222; t_ss = 16'h4000; t_ds = 16'h0800;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1", "out_valid", {31'h0, out_valid}, 32'h0);
        chk("R1", "out_offset", {16'h0, out_offset}, 32'h0);
        chk("R1", "out_phys", {12'h0, out_phys}, 32'h0);
        chk("R1", "out_is_reg", {31'h0, out_is_reg}, 32'h0);
        load_regs();
        // R2 R3: every base with mode 00 (displacement input must not count)
        for (int r = 0; r < 8; r++)
            txn(2'b00, 3'(r), 1'b1, 16'h7777, (r == 6) ? "R6" : "R2_R3");
        // R4: short displacement, negative, junk in high byte
        for (int r = 0; r < 8; r++) txn(2'b01, 3'(r), 1'b0, 16'hAB80, "R4");
        txn(2'b01, 3'd7, 1'b1, 16'hFF7F, "R4");
        // R5: long displacement
        for (int r = 0; r < 8; r++) txn(2'b10, 3'(r), 1'b1, 16'h8123, "R5");
        // R7: register operands
        for (int r = 0; r < 8; r++) begin
            txn(2'b11, 3'(r), 1'b0, 16'h0, "R7");
            txn(2'b11, 3'(r), 1'b1, 16'h0, "R7");
        end
        // R8 R10: worked address cases
        t_ds = 16'h0100; t_bx = 16'h1000; t_di = 16'h0010;
        txn(2'b00, 3'd1, 1'b1, 16'h0, "R8");
        t_ss = 16'h5000; t_bp = 16'hFFE0;
        txn(2'b01, 3'd6, 1'b1, 16'h0000, "R10");
        t_ds = 16'h348A;
        txn(2'b00, 3'd6, 1'b1, 16'h0000, "R6");
        // R9: offset wrap
        t_bx = 16'hFFFF; t_si = 16'h0002;
        txn(2'b10, 3'd0, 1'b1, 16'hFFFF, "R9");
        // R8: physical wrap above 20 bits
        t_ds = 16'hFFFF;
        txn(2'b00, 3'd6, 1'b1, 16'hFFF0, "R8");
        // R12: requests held high while busy, inputs churning
        load_regs();
        step(1'b1, 2'b10, 3'd3, 1'b1, 16'h0101, "R12");
        for (int i = 0; i < 6; i++) begin
            t_bx = 16'(i * 16'h1357); t_bp = 16'(i * 16'h2468); t_si = 16'(i + 7);
            t_di = 16'(i * 3); t_ss = 16'(16'h9000 + i); t_ds = 16'(16'h0A00 + i);
            step(1'b1, 2'(i), 3'(i + 1), 1'(i), 16'(i * 16'h0F0F), "R12");
        end
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 3'd0, 1'b0, 16'h0, "R12");
        // mixed stream, R11 timing across random back-to-back traffic
        for (int i = 0; i < 300; i++) begin
            t_bx = 16'($urandom); t_bp = 16'($urandom); t_si = 16'($urandom); t_di = 16'($urandom);
            t_es = 16'($urandom); t_cs = 16'($urandom); t_ss = 16'($urandom); t_ds = 16'($urandom);
            step(($urandom % 3) != 0, 2'($urandom), 3'($urandom), 1'($urandom), 16'($urandom), "R11");
        end
        for (int i = 0; i < 6; i++) step(1'b0, 2'b00, 3'd0, 1'b0, 16'h0, "R11");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule